// File: doc/BRIEF.md
# Selector Channel DMA Sequencer

This block is a single-channel DMA sequencer sitting on a byte-wide I/O bus. A host loads a start and an end address by writing a stream of bytes into a rippling load sequencer. It can read the current start address back one byte at a time, issue 8-bit command bytes that arm or halt the channel, and poll a status byte. The number of bytes the sequencer accepts depends on the address mode: a 16-bit mode, an 18-bit banked mode where the command carries two bank bits, and a wide mode that covers the full physical address width.

Once armed by a go command, the channel serves an attached device. The device asks for a block of bytes, and the block moves one byte per acknowledged memory cycle. The current address advances past each byte. When the byte at the end address has moved, the channel raises its interrupt and drops busy, and the start address is left on that last byte. The device can also halt the channel itself. A device-facing active flag tells a device whether the channel is armed for its number.

Top module: `selch_dma`

## Requirements
- R1: After reset the start and end addresses, the write counter, all command bits and the interrupt are zero, and the readback pointer is 1.
- R2: addr_mode encodes 00 = 16-bit, 01 = 18-bit banked, 10 = wide, 11 = 16-bit. Outside wide mode, each host byte write sets start = {start[7:0], end[15:8]} and end = {end[7:0], byte}, both kept to 16 bits. Writes after the fourth since the last stop leave both addresses unchanged.
- R3: In wide mode up to six writes are accepted. Writes one to five behave as in R2, except that the start address keeps ADDR_W bits. The sixth write sets end = {end[ADDR_W-9:0], byte}. Later writes are ignored.
- R4: host_rd_data shows start-address byte number p, where p is the readback pointer (0 = bits 7:0, 1 = bits 15:8, 2 = bits ADDR_W-1:16). Each host_rd_en strobe decrements p. From 0, p wraps to 2 when extended readback is set in wide mode, and to 1 otherwise.
- R5: Command bits are: bit 6 extended readback, bit 5 read direction, bit 4 go, bit 3 stop, bit 2 channel-status select, bits 1:0 bank. Outside wide mode, bits 6 and 2 of an incoming command are treated as zero. A command with neither stop nor go set has no effect.
- R6: Stop wins over go. A stop keeps only bits 6 and 2 of the command. It clears go, read and the interrupt, sets the pointer to 2 (extended readback in wide mode) or 1, and clears the write counter.
- R7: A go command latches bits 6, 5, 4 and 2. If four or fewer bytes were written, both addresses are cut to 16 bits and bits 1:0 are placed in bits 17:16, in banked mode only. Start bit 0 is then cleared. If end <= start, end is ORed with 0xFFFF (or all ones in wide mode).
- R8: host_status is 0x08 (bit 3 busy) while go is set. Otherwise it is 0x00 when status select is set, or dev_status with bit 3 cleared.
- R9: A dev_xfer_start with a non-zero count is accepted while go is set and no block is in progress. The block moves min(count, end - start + 1) bytes, one per cycle with mem_req and mem_ack both high. mem_addr shows the current start address, and mem_we is the inverse of the read bit.
- R10: When the byte at the end address moves, irq rises, go and read clear, and the start address stays on that byte. Any other byte moved advances the start address by one.
- R11: dev_stop raises irq and clears go and read.
- R12: dev_sel_en stores dev_sel_num. dev_active is high exactly while go is set and the stored number equals dev_id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_mode | input | 2 | Address mode (see R2) |
| host_wr_en | input | 1 | Address byte write strobe |
| host_wr_data | input | 8 | Address byte |
| host_rd_en | input | 1 | Readback strobe, advances the pointer |
| host_rd_data | output | 8 | Start-address byte at the pointer |
| host_cmd_en | input | 1 | Command strobe |
| host_cmd | input | 8 | Command byte |
| host_status | output | 8 | Status byte |
| dev_status | input | 8 | Attached device status |
| dev_sel_en | input | 1 | Store device number |
| dev_sel_num | input | DEV_W | Device number to store |
| dev_id | input | DEV_W | Device number being asked about |
| dev_active | output | 1 | Channel armed for dev_id |
| dev_xfer_start | input | 1 | Block request strobe |
| dev_xfer_count | input | CNT_W | Requested byte count |
| dev_xfer_busy | output | 1 | Block in progress |
| dev_stop | input | 1 | Device-side halt |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | 1 = write to memory |
| mem_addr | output | ADDR_W | Current start address |
| mem_ack | input | 1 | Memory byte acknowledge |
| irq | output | 1 | Channel interrupt |

## Verification
Random byte streams are loaded in each address mode. They show whether the ripple order and the acceptance limit are right (four bytes versus six), because the readback bytes and mem_addr differ as soon as one byte lands in the wrong place. Go commands after short and long loads, with end both above and below start, show apart the 16-bit cut, the bank insertion and the end-forcing rule. Block requests both shorter and longer than the remaining span show whether the count or the end address terminates a block, which the moved-byte count and the final address reveal. Random mixes of stop, go, device halt and device-number changes check the interrupt, the status byte and dev_active against a bench model.

// File: rtl/selch_pkg.sv
package selch_pkg;
   localparam int CB_EXA  = 6;
   localparam int CB_RD   = 5;
   localparam int CB_GO   = 4;
   localparam int CB_STOP = 3;
   localparam int CB_SSTA = 2;
   localparam int ST_BUSY = 3;

   typedef enum logic [1:0] {
      AM_NARROW = 2'b00,
      AM_BANKED = 2'b01,
      AM_WIDE   = 2'b10,
      AM_RSVD   = 2'b11
   } amode_e;
endpackage

// File: rtl/selch_loadseq.sv
module selch_loadseq #(
   parameter int ADDR_W = 20
) (
   input  logic              wide,
   input  logic [ADDR_W-1:0] sa,
   input  logic [ADDR_W-1:0] ea,
   input  logic [2:0]        wcnt,
   input  logic [7:0]        din,
   output logic              accept,
   output logic [ADDR_W-1:0] sa_n,
   output logic [ADDR_W-1:0] ea_n,
   output logic [2:0]        wcnt_n
);
   localparam logic [2:0]        CAP_NARROW = 3'd4;
   localparam logic [2:0]        CAP_WIDE   = 3'd6;
   localparam logic [2:0]        LAST_WIDE  = CAP_WIDE - 3'd1;
   localparam logic [ADDR_W-1:0] MASK_ALL   = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] MASK_16    = {{(ADDR_W-16){1'b0}}, 16'hFFFF};

   always_comb begin
      accept = wcnt < (wide ? CAP_WIDE : CAP_NARROW);
      sa_n   = sa;
      ea_n   = ea;
      wcnt_n = wcnt;
      if (accept) begin
         wcnt_n = wcnt + 3'd1;
         if (wide && (wcnt == LAST_WIDE)) begin
            ea_n = {ea[ADDR_W-9:0], din};
         end else begin
            sa_n = {sa[ADDR_W-9:0], ea[15:8]} & (wide ? MASK_ALL : MASK_16);
            ea_n = {{(ADDR_W-16){1'b0}}, ea[7:0], din};
         end
      end
   end
endmodule

// File: rtl/selch_rdback.sv
module selch_rdback #(
   parameter int ADDR_W = 20
) (
   input  logic [ADDR_W-1:0] sa,
   input  logic [1:0]        ptr,
   input  logic              ext,
   output logic [7:0]        byte_o,
   output logic [1:0]        ptr_n
);
   localparam int NB = (ADDR_W + 7) / 8;

   logic [7:0] lanes [NB];

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign lanes[g] = 8'(sa >> (8 * g));
   end

   assign byte_o = (32'(ptr) < NB) ? lanes[ptr] : 8'h00;
   assign ptr_n  = (ptr == 2'd0) ? (ext ? 2'd2 : 2'd1) : ptr - 2'd1;
endmodule

// File: rtl/selch_xfer.sv
module selch_xfer #(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  count,
   input  logic              go,
   input  logic              stall,
   input  logic [ADDR_W-1:0] sa,
   input  logic [ADDR_W-1:0] ea,
   input  logic              mem_ack,
   output logic              mem_req,
   output logic              fire,
   output logic              at_end,
   output logic              busy
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             active_q;
   logic [CNT_W-1:0] rem_q;

   assign mem_req = active_q && go && !stall;
   assign fire    = mem_req && mem_ack;
   assign at_end  = fire && (sa == ea);
   assign busy    = active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rem_q    <= '0;
      end else if (!go) begin
         active_q <= 1'b0;
      end else if (fire) begin
         rem_q <= rem_q - ONE;
         if (at_end || (rem_q == ONE)) active_q <= 1'b0;
      end else if (start && !active_q && (count != '0)) begin
         active_q <= 1'b1;
         rem_q    <= count;
      end
   end

   AST_FIRE_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (rem_q != '0)); // R9
endmodule

// File: rtl/selch_dma.sv
module selch_dma
   import selch_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 8,
   parameter int DEV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr_mode,
   input  logic              host_wr_en,
   input  logic [7:0]        host_wr_data,
   input  logic              host_rd_en,
   output logic [7:0]        host_rd_data,
   input  logic              host_cmd_en,
   input  logic [7:0]        host_cmd,
   output logic [7:0]        host_status,
   input  logic [7:0]        dev_status,
   input  logic              dev_sel_en,
   input  logic [DEV_W-1:0]  dev_sel_num,
   input  logic [DEV_W-1:0]  dev_id,
   output logic              dev_active,
   input  logic              dev_xfer_start,
   input  logic [CNT_W-1:0]  dev_xfer_count,
   output logic              dev_xfer_busy,
   input  logic              dev_stop,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] MASK_ALL = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] MASK_16  = {{(ADDR_W-16){1'b0}}, 16'hFFFF};
   localparam logic [7:0]        EXT_BITS = 8'((1 << CB_EXA) | (1 << CB_SSTA));
   localparam logic [7:0]        BUSY_VAL = 8'(1 << ST_BUSY);
   localparam logic [2:0]        SHORT_LD = 3'd4;

   if (ADDR_W < 18 || ADDR_W > 24) begin : g_chk_aw
      $error("selch_dma: ADDR_W must lie in 18..24");
   end
   if (CNT_W < 1 || DEV_W < 1) begin : g_chk_w
      $error("selch_dma: CNT_W and DEV_W must be positive");
   end

   logic [ADDR_W-1:0] sa_q, ea_q;
   logic              exa_q, rd_q, go_q, ssta_q, irq_q;
   logic [1:0]        rdp_q;
   logic [2:0]        wcnt_q;
   logic [DEV_W-1:0]  sdv_q;

   logic              wide;
   logic [7:0]        cmd_eff;
   logic [ADDR_W-1:0] bank_w, go_sa, go_ea;

   logic              ld_accept;
   logic [ADDR_W-1:0] ld_sa, ld_ea;
   logic [2:0]        ld_wcnt;
   logic [1:0]        rb_ptr_n;
   logic              xf_fire, xf_end, xf_stall;

   assign wide    = (amode_e'(addr_mode) == AM_WIDE);
   assign cmd_eff = wide ? host_cmd : (host_cmd & ~EXT_BITS);
   assign bank_w  = (amode_e'(addr_mode) == AM_BANKED) ? (ADDR_W'(cmd_eff[1:0]) << 16) : '0;

   always_comb begin
      go_sa = sa_q;
      go_ea = ea_q;
      if (wcnt_q <= SHORT_LD) begin
         go_sa = (sa_q & MASK_16) | bank_w;
         go_ea = (ea_q & MASK_16) | bank_w;
      end
      go_sa[0] = 1'b0;
      if (go_ea <= go_sa) go_ea = go_ea | (wide ? MASK_ALL : MASK_16);
   end

   selch_loadseq #(.ADDR_W(ADDR_W)) u_load (
      .wide(wide), .sa(sa_q), .ea(ea_q), .wcnt(wcnt_q), .din(host_wr_data),
      .accept(ld_accept), .sa_n(ld_sa), .ea_n(ld_ea), .wcnt_n(ld_wcnt)
   );

   selch_rdback #(.ADDR_W(ADDR_W)) u_rdback (
      .sa(sa_q), .ptr(rdp_q), .ext(exa_q && wide),
      .byte_o(host_rd_data), .ptr_n(rb_ptr_n)
   );

   assign xf_stall = host_cmd_en || host_wr_en || dev_stop;

   selch_xfer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xfer (
      .clk(clk), .rst_n(rst_n), .start(dev_xfer_start), .count(dev_xfer_count),
      .go(go_q), .stall(xf_stall), .sa(sa_q), .ea(ea_q), .mem_ack(mem_ack),
      .mem_req(mem_req), .fire(xf_fire), .at_end(xf_end), .busy(dev_xfer_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sa_q   <= '0;
         ea_q   <= '0;
         exa_q  <= 1'b0;
         rd_q   <= 1'b0;
         go_q   <= 1'b0;
         ssta_q <= 1'b0;
         irq_q  <= 1'b0;
         rdp_q  <= 2'd1;
         wcnt_q <= '0;
         sdv_q  <= '0;
      end else begin
         if (host_cmd_en) begin
            if (cmd_eff[CB_STOP]) begin
               exa_q  <= cmd_eff[CB_EXA];
               ssta_q <= cmd_eff[CB_SSTA];
               go_q   <= 1'b0;
               rd_q   <= 1'b0;
               irq_q  <= 1'b0;
               rdp_q  <= (cmd_eff[CB_EXA] && wide) ? 2'd2 : 2'd1;
               wcnt_q <= '0;
            end else if (cmd_eff[CB_GO]) begin
               exa_q  <= cmd_eff[CB_EXA];
               ssta_q <= cmd_eff[CB_SSTA];
               rd_q   <= cmd_eff[CB_RD];
               go_q   <= 1'b1;
               sa_q   <= go_sa;
               ea_q   <= go_ea;
            end
         end else begin
            if (host_wr_en) begin
               sa_q   <= ld_sa;
               ea_q   <= ld_ea;
               wcnt_q <= ld_wcnt;
            end else if (host_rd_en) begin
               rdp_q <= rb_ptr_n;
            end
            if (dev_stop || xf_end) begin
               irq_q <= 1'b1;
               go_q  <= 1'b0;
               rd_q  <= 1'b0;
            end else if (xf_fire) begin
               sa_q <= sa_q + 1'b1;
            end
         end
         if (dev_sel_en) sdv_q <= dev_sel_num;
      end
   end

   assign host_status = go_q ? BUSY_VAL : (ssta_q ? 8'h00 : (dev_status & ~BUSY_VAL));
   assign dev_active  = go_q && (sdv_q == dev_id);
   assign mem_we      = !rd_q;
   assign mem_addr    = sa_q;
   assign irq         = irq_q;

   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rdp_q != 2'd3); // R4
   AST_NARROW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_en && !host_cmd_en && !wide && (wcnt_q >= SHORT_LD)) |=> $stable(mem_addr)); // R2
   AST_WIDE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_en && !host_cmd_en && wide && !ld_accept) |=> ($stable(mem_addr) && $stable(ea_q))); // R3
   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cmd_en && cmd_eff[CB_STOP]) |=> (!host_status[ST_BUSY] && !irq)); // R6
   AST_GO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cmd_en && !cmd_eff[CB_STOP] && cmd_eff[CB_GO]) |=> (!mem_addr[0] && (ea_q > mem_addr))); // R7
   AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> host_status[ST_BUSY]); // R9
   AST_END_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && (mem_addr == ea_q)) |=> (irq && !host_status[ST_BUSY] && $stable(mem_addr))); // R10
   AST_DEV_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_stop && !host_cmd_en) |=> (irq && !host_status[ST_BUSY])); // R11
endmodule

// File: tb/selch_dma_bench.sv
module selch_dma_bench;
   localparam int AW = 20;
   localparam logic [AW-1:0] M_ALL = {AW{1'b1}};
   localparam logic [AW-1:0] M_16  = 20'h0FFFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] addr_mode = 2'b00;
   logic host_wr_en = 0, host_rd_en = 0, host_cmd_en = 0;
   logic [7:0] host_wr_data = 0, host_cmd = 0, dev_status = 8'h5A;
   logic [7:0] host_rd_data, host_status;
   logic dev_sel_en = 0, dev_xfer_start = 0, dev_stop = 0, mem_ack = 0;
   logic [7:0] dev_sel_num = 0, dev_id = 0, dev_xfer_count = 0;
   logic dev_active, dev_xfer_busy, mem_req, mem_we, irq;
   logic [AW-1:0] mem_addr;

   always #4 clk = ~clk;

   selch_dma u_selch_dma (
      .clk(clk), .rst_n(rst_n), .addr_mode(addr_mode),
      .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
      .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
      .host_cmd_en(host_cmd_en), .host_cmd(host_cmd), .host_status(host_status),
      .dev_status(dev_status), .dev_sel_en(dev_sel_en), .dev_sel_num(dev_sel_num),
      .dev_id(dev_id), .dev_active(dev_active), .dev_xfer_start(dev_xfer_start),
      .dev_xfer_count(dev_xfer_count), .dev_xfer_busy(dev_xfer_busy), .dev_stop(dev_stop),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack), .irq(irq)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   logic [AW-1:0] m_sa = 0, m_ea = 0;
   logic m_exa = 0, m_rd = 0, m_go = 0, m_ssta = 0, m_irq = 0;
   logic [1:0] m_rdp = 2'd1;
   int m_wdc = 0;
   logic [7:0] m_sdv = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit is_wide();
      return addr_mode == 2'b10;
   endfunction

   function automatic logic [7:0] exp_byte();
      case (m_rdp)
         2'd0: return m_sa[7:0];
         2'd1: return m_sa[15:8];
         2'd2: return 8'(m_sa[AW-1:16]);
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] exp_status();
      if (m_go) return 8'h08;
      if (m_ssta) return 8'h00;
      return dev_status & 8'hF7;
   endfunction

   task automatic check_state(input string tag);
      chk({tag, " addr"}, mem_addr, m_sa);
      chk({tag, " irq"}, irq, m_irq);
      chk({tag, " status"}, host_status, exp_status());
      chk({tag, " rdbyte"}, host_rd_data, exp_byte());
      chk({tag, " active"}, dev_active, m_go && (m_sdv == dev_id));
   endtask

   task automatic do_write(input logic [7:0] b, input string tag);
      int cap;
      host_wr_en = 1; host_wr_data = b;
      @(negedge clk);
      host_wr_en = 0;
      cap = is_wide() ? 6 : 4;
      if (m_wdc < cap) begin
         if (is_wide() && m_wdc == 5) m_ea = ((m_ea << 8) | AW'(b)) & M_ALL;
         else begin
            m_sa = ((m_sa << 8) | AW'(m_ea[15:8])) & (is_wide() ? M_ALL : M_16);
            m_ea = ((m_ea << 8) | AW'(b)) & M_16;
         end
         m_wdc++;
      end
      check_state(tag);
   endtask

   task automatic do_cmd(input logic [7:0] c, input string tag);
      logic [7:0] e;
      logic [AW-1:0] bank;
      host_cmd_en = 1; host_cmd = c;
      @(negedge clk);
      host_cmd_en = 0;
      e = is_wide() ? c : (c & 8'hBB);
      if (e[3]) begin
         m_exa = e[6]; m_ssta = e[2]; m_go = 0; m_rd = 0; m_irq = 0;
         m_rdp = (e[6] && is_wide()) ? 2'd2 : 2'd1; m_wdc = 0;
      end else if (e[4]) begin
         m_exa = e[6]; m_ssta = e[2]; m_rd = e[5]; m_go = 1;
         bank = (addr_mode == 2'b01) ? (AW'(e[1:0]) << 16) : '0;
         if (m_wdc <= 4) begin
            m_sa = (m_sa & M_16) | bank;
            m_ea = (m_ea & M_16) | bank;
         end
         m_sa[0] = 1'b0;
         if (m_ea <= m_sa) m_ea = m_ea | (is_wide() ? M_ALL : M_16);
      end
      check_state(tag);
   endtask

   task automatic do_read(input string tag);
      chk({tag, " byte"}, host_rd_data, exp_byte());
      host_rd_en = 1;
      @(negedge clk);
      host_rd_en = 0;
      m_rdp = (m_rdp == 2'd0) ? ((m_exa && is_wide()) ? 2'd2 : 2'd1) : m_rdp - 2'd1;
      check_state(tag);
   endtask

   task automatic do_sel(input logic [7:0] num, input logic [7:0] id, input string tag);
      dev_sel_en = 1; dev_sel_num = num;
      @(negedge clk);
      dev_sel_en = 0; dev_id = id;
      m_sdv = num;
      #1;
      check_state(tag);
   endtask

   task automatic do_dstop(input string tag);
      dev_stop = 1;
      @(negedge clk);
      dev_stop = 0;
      m_irq = 1; m_go = 0; m_rd = 0;
      check_state(tag);
   endtask

   task automatic do_xfer(input int n, input string tag);
      longint span, exp_moved;
      int moved, rem;
      bit fin;
      if (!m_go || n == 0) exp_moved = 0;
      else begin
         span = (m_sa <= m_ea) ? longint'(m_ea - m_sa) + 1 : 64'd1 << 30;
         exp_moved = (longint'(n) < span) ? n : span;
      end
      dev_xfer_start = 1; dev_xfer_count = 8'(n);
      @(negedge clk);
      dev_xfer_start = 0; mem_ack = 1;
      moved = 0; rem = n; fin = (exp_moved == 0);
      for (int i = 0; i < 300 && !fin; i++) begin
         if (!mem_req) begin
            fin = 1;
         end else begin
            chk({tag, " xaddr"}, mem_addr, m_sa);
            chk({tag, " we"}, mem_we, !m_rd);
            @(negedge clk);
            moved++;
            if (m_sa == m_ea) begin
               m_irq = 1; m_go = 0; m_rd = 0; fin = 1;
            end else begin
               m_sa = m_sa + 1'b1; rem--;
               if (rem == 0) fin = 1;
            end
         end
      end
      mem_ack = 0;
      chk({tag, " moved"}, moved, exp_moved);
      chk({tag, " req_off"}, mem_req, 0);
      check_state(tag);
   endtask

   task automatic set_mode(input logic [1:0] md);
      addr_mode = md;
      do_cmd(8'h08, "R6 mode change stop");
   endtask

   task automatic rand_ops(input int cnt);
      for (int i = 0; i < cnt; i++) begin
         int op;
         op = int'($urandom % 10);
         case (op)
            0, 1, 2, 3: do_write(8'($urandom), is_wide() ? "R3 rand write" : "R2 rand write");
            4: do_read("R4 rand read");
            5: begin
               logic [7:0] c;
               c = 8'($urandom);
               if ($urandom % 2) c = (c & 8'hE7) | 8'h10;
               do_cmd(c, "R7 rand cmd");
            end
            6: do_xfer(1 + int'($urandom % 40), "R9 rand xfer");
            7: do_sel(8'($urandom % 4), 8'($urandom % 4), "R12 rand sel");
            8: do_dstop("R11 rand dstop");
            default: begin
               dev_status = 8'($urandom);
               #1;
               check_state("R8 rand status");
            end
         endcase
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check_state("R1 reset");
      chk("R1 wcnt via cap", dev_xfer_busy, 0);

      // 16-bit mode: ripple load and cap of four
      do_write(8'h12, "R2 w1"); do_write(8'h34, "R2 w2");
      do_write(8'h56, "R2 w3"); do_write(8'h78, "R2 w4");
      chk("R2 start after four", mem_addr, 20'h01234);
      do_write(8'h9A, "R2 fifth ignored");
      chk("R2 start unchanged", mem_addr, 20'h01234);
      do_read("R4 p1"); do_read("R4 p0"); do_read("R4 wrap to 1");
      do_cmd(8'h54, "R5 ext bits dropped");
      do_cmd(8'h4C, "R6 stop drops ext");
      dev_status = 8'hFF; #1;
      check_state("R5 status bit ignored");
      // go with end below start
      do_write(8'h80, "R2 a"); do_write(8'h00, "R2 b");
      do_write(8'h10, "R2 c"); do_write(8'h01, "R2 d");
      do_cmd(8'h30, "R7 end forced");
      do_xfer(8, "R9 count limited");
      chk("R9 start advanced", mem_addr, 20'h08008);
      do_cmd(8'h08, "R6 stop");
      do_write(8'h00, "R2 e"); do_write(8'h11, "R2 f");
      do_write(8'h00, "R2 g"); do_write(8'h14, "R2 h");
      do_cmd(8'h10, "R7 even start");
      chk("R7 bit0 cleared", mem_addr, 20'h00010);
      do_sel(8'h05, 8'h05, "R12 match");
      do_sel(8'h05, 8'h06, "R12 mismatch");
      do_xfer(200, "R10 end reached");
      chk("R10 irq", irq, 1);
      chk("R10 rests on end", mem_addr, 20'h00014);
      do_cmd(8'h0C, "R6 stop clears irq");
      do_cmd(8'h01, "R5 no-op command");
      do_cmd(8'h10, "R7 re-go");
      do_dstop("R11 device stop");
      rand_ops(250);

      // banked mode
      set_mode(2'b01);
      do_write(8'h40, "R2 bank a"); do_write(8'h00, "R2 bank b");
      do_write(8'h50, "R2 bank c"); do_write(8'h00, "R2 bank d");
      do_cmd(8'h13, "R7 bank bits");
      chk("R7 bank placed", mem_addr, 20'h34000);
      do_xfer(3, "R9 banked xfer");
      rand_ops(250);

      // wide mode
      set_mode(2'b10);
      do_cmd(8'h48, "R6 stop ext ptr");
      for (int k = 1; k <= 7; k++) do_write(8'(k * 17), "R3 wide load");
      do_read("R4 wide p2"); do_read("R4 wide p1");
      do_read("R4 wide p0"); do_read("R4 wide wrap 2");
      do_cmd(8'h54, "R7 long load no cut");
      do_cmd(8'h0C, "R8 status select");
      dev_status = 8'hAA; #1;
      check_state("R8 status zero");
      rand_ops(300);

      set_mode(2'b11);
      rand_ops(150);
      done = 1;
   end

   initial begin
      fork
         begin
            repeat (200000) @(posedge clk);
            if (!done) begin
               n_chk++; n_bad++;
               $display("FAIL watchdog expired actual=running expected=finished");
            end
         end
         wait (done);
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule